// File: doc/BRIEF.md
# SAR Slice Conversion Sequencer

This block is the control state machine for a single successive-approximation slice inside an interleaved converter. Each conversion runs as a rigid frame of `RES_W + 5` clock cycles, which is 16 at the default 11-bit resolution. The frame starts with three housekeeping slots that request the analog correction loops: a reference-zero sample, an offset (auto-zero) comparison and a gain (auto-calibrate) comparison. One slot then samples the input. After that comes one bit decision per cycle, most significant bit first. A final slot hands the finished word out of the slice.

The block drives the trial code for the slice DAC and a one-hot set of phase strobes for the analog section. It also holds the completed result, which changes only on entry to the transfer slot; the transfer strobe marks that slot. The comparator decision comes back on `cmp_keep`. A frame begins only on `frame_start`, sampled while the sequencer is idle or in its transfer slot. A parent that asserts the strobe during every transfer slot gets back-to-back frames with no gap.

States are `ST_IDLE`, `ST_ZREF`, `ST_AZERO`, `ST_ACAL`, `ST_SAMPLE`, `ST_CONV` and `ST_XFER`. The transitions are:
- `ST_IDLE` goes to `ST_ZREF` on start, otherwise it stays.
- `ST_ZREF` goes to `ST_AZERO`, then `ST_ACAL`, then `ST_SAMPLE`, then `ST_CONV`, each unconditionally.
- `ST_CONV` stays while bits remain and moves to `ST_XFER` after the last bit.
- `ST_XFER` goes to `ST_ZREF` on start, otherwise to `ST_IDLE`.

Top module: `sar_slice_seq`

## Requirements
- R1: While reset is asserted, every phase strobe, `trial_code` and `result` are zero.
- R2: `frame_start` seen high at an edge in idle makes the next cycle frame cycle 1. The frame then runs through zero-sample (cycle 1), auto-zero (cycle 2), auto-cal (cycle 3), sample (cycle 4), convert (cycles 5 to 15) and transfer (cycle 16).
- R3: During every frame cycle exactly one of the six phase strobes is high, and in idle none is high.
- R4: In convert cycle k (k = 0 for cycle 5), `trial_code` equals the already-decided upper bits with bit `RES_W-1-k` set to 1 and all lower bits 0.
- R5: `cmp_keep` high at the edge that ends a convert cycle keeps the trial bit at 1, and low clears it to 0.
- R6: In the transfer cycle `result` equals the code decided by the eleven comparisons, and `ph_xfer` is high for exactly that one cycle.
- R7: `result` keeps its value from one transfer cycle until the next transfer cycle, including through idle periods.
- R8: `frame_start` high during cycles 1 to 15 of a frame has no effect on the phase sequence, the trial codes or the result.
- R9: `frame_start` high during the transfer cycle makes the following cycle frame cycle 1. Without it the sequencer goes idle.
- R10: Outside convert cycles `trial_code` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Frame request, honoured only in idle or in the transfer cycle |
| cmp_keep | input | 1 | Comparator decision: 1 keeps the current trial bit |
| trial_code | output | RES_W | Code presented to the slice DAC |
| ph_zref | output | 1 | Reference-zero sampling phase |
| ph_azero | output | 1 | Offset comparison phase |
| ph_acal | output | 1 | Gain comparison phase |
| ph_sample | output | 1 | Input sampling phase |
| ph_convert | output | 1 | Bit decision phase |
| ph_xfer | output | 1 | Transfer phase, the one-cycle result strobe |
| result | output | RES_W | Last completed conversion word |

## Verification
The assertions assume that `cmp_keep` is a valid level during every convert cycle and that `frame_start` is a clean synchronous level. Under those assumptions, phase order, the trial code after sampling and result stability follow from the sequencer alone.

The bench models the comparator as an ideal compare of a held input value against `trial_code`. It changes that value and `frame_start` only a short time after a rising edge, so both stay steady across each sampling edge. A sweep over all 2048 input codes exercises every keep/clear pattern, and mid-frame start pulses are injected along the way.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ZREF,
        ST_AZERO,
        ST_ACAL,
        ST_SAMPLE,
        ST_CONV,
        ST_XFER
    } seq_state_t;

    typedef struct packed {
        logic zref;
        logic azero;
        logic acal;
        logic sample;
        logic convert;
        logic xfer;
    } phase_t;

endpackage

// File: rtl/sar_frame_fsm.sv
`timescale 1ns/1ps
module sar_frame_fsm
    import sar_seq_pkg::*;
#(
    parameter int RES_W = 11
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           frame_start,
    output seq_state_t                     state,
    output logic [$clog2(RES_W)-1:0]       bit_idx,
    output logic                           last_bit
);

    localparam int IDX_W = $clog2(RES_W);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_d;

    assign last_bit = (state_q == ST_CONV) && (idx_q == '0);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = frame_start ? ST_ZREF : ST_IDLE;
            ST_ZREF:   state_d = ST_AZERO;
            ST_AZERO:  state_d = ST_ACAL;
            ST_ACAL:   state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = ST_CONV;
            ST_CONV:   state_d = last_bit ? ST_XFER : ST_CONV;
            ST_XFER:   state_d = frame_start ? ST_ZREF : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // bit pointer: loaded while sampling, walks down during conversion
    always_comb begin
        idx_d = idx_q;
        unique case (state_q)
            ST_SAMPLE: idx_d = TOP_IDX;
            ST_CONV:   idx_d = last_bit ? '0 : idx_q - 1'b1;
            default:   idx_d = idx_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    assign state   = state_q;
    assign bit_idx = idx_q;

endmodule

// File: rtl/sar_phase_decode.sv
`timescale 1ns/1ps
module sar_phase_decode
    import sar_seq_pkg::*;
(
    input  seq_state_t state,
    output phase_t     phase
);

    always_comb begin
        phase = '0;
        unique case (state)
            ST_IDLE:   phase = '0;
            ST_ZREF:   phase.zref    = 1'b1;
            ST_AZERO:  phase.azero   = 1'b1;
            ST_ACAL:   phase.acal    = 1'b1;
            ST_SAMPLE: phase.sample  = 1'b1;
            ST_CONV:   phase.convert = 1'b1;
            ST_XFER:   phase.xfer    = 1'b1;
            default:   phase = '0;
        endcase
    end

endmodule

// File: rtl/sar_bit_search.sv
`timescale 1ns/1ps
module sar_bit_search #(
    parameter int RES_W = 11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      step,
    input  logic                      last_bit,
    input  logic [$clog2(RES_W)-1:0]  bit_idx,
    input  logic                      cmp_keep,
    output logic [RES_W-1:0]          trial_code,
    output logic [RES_W-1:0]          result
);

    logic [RES_W-1:0] acc_q;
    logic [RES_W-1:0] acc_d;
    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] mask;
    logic [RES_W-1:0] trial;

    assign mask  = RES_W'(1) << bit_idx;
    assign trial = acc_q | mask;
    assign acc_d = cmp_keep ? trial : (acc_q & ~mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            res_q <= '0;
        end else begin
            if (clear) begin
                acc_q <= '0;
            end else if (step) begin
                acc_q <= acc_d;
                if (last_bit) begin
                    res_q <= acc_d;
                end
            end
        end
    end

    assign trial_code = step ? trial : '0;
    assign result     = res_q;

endmodule

// File: rtl/sar_slice_seq.sv
`timescale 1ns/1ps
module sar_slice_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             cmp_keep,
    output logic [RES_W-1:0] trial_code,
    output logic             ph_zref,
    output logic             ph_azero,
    output logic             ph_acal,
    output logic             ph_sample,
    output logic             ph_convert,
    output logic             ph_xfer,
    output logic [RES_W-1:0] result
);

    localparam int IDX_W = $clog2(RES_W);

    seq_state_t       state;
    phase_t           phase;
    logic [IDX_W-1:0] bit_idx;
    logic             last_bit;

    sar_frame_fsm #(.RES_W(RES_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .state       (state),
        .bit_idx     (bit_idx),
        .last_bit    (last_bit)
    );

    sar_phase_decode u_dec (
        .state (state),
        .phase (phase)
    );

    sar_bit_search #(.RES_W(RES_W)) u_search (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (phase.sample),
        .step       (phase.convert),
        .last_bit   (last_bit),
        .bit_idx    (bit_idx),
        .cmp_keep   (cmp_keep),
        .trial_code (trial_code),
        .result     (result)
    );

    assign ph_zref    = phase.zref;
    assign ph_azero   = phase.azero;
    assign ph_acal    = phase.acal;
    assign ph_sample  = phase.sample;
    assign ph_convert = phase.convert;
    assign ph_xfer    = phase.xfer;

endmodule

// File: rtl/sar_slice_seq_chk.sv
`timescale 1ns/1ps
module sar_slice_seq_chk #(
    parameter int RES_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic [RES_W-1:0] trial_code,
    input logic             ph_zref,
    input logic             ph_azero,
    input logic             ph_acal,
    input logic             ph_sample,
    input logic             ph_convert,
    input logic             ph_xfer,
    input logic [RES_W-1:0] result
);

    localparam int CNT_W = $clog2(RES_W + 1);

    logic [5:0]       ph_all;
    logic [CNT_W-1:0] conv_cnt;

    assign ph_all = {ph_zref, ph_azero, ph_acal, ph_sample, ph_convert, ph_xfer};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_cnt <= '0;
        end else if (ph_sample) begin
            conv_cnt <= '0;
        end else if (ph_convert) begin
            conv_cnt <= conv_cnt + 1'b1;
        end
    end

    // R2: exactly RES_W decision cycles precede each transfer
    always @(posedge clk) begin
        if (rst_n && ph_xfer) begin
            a_r2_conv_len: assert (conv_cnt == CNT_W'(RES_W))
                else $error("convert run length wrong");
        end
    end

    a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ph_all));

    a_r2_zref_next: assert property (@(posedge clk) disable iff (!rst_n)
        ph_zref |=> ph_azero);
    a_r2_azero_next: assert property (@(posedge clk) disable iff (!rst_n)
        ph_azero |=> ph_acal);
    a_r2_acal_next: assert property (@(posedge clk) disable iff (!rst_n)
        ph_acal |=> ph_sample);
    a_r8_sample_next: assert property (@(posedge clk) disable iff (!rst_n)
        ph_sample |=> ph_convert);
    a_r8_conv_next: assert property (@(posedge clk) disable iff (!rst_n)
        ph_convert |=> (ph_convert || ph_xfer));

    a_r4_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
        ph_sample |=> (trial_code == {1'b1, {(RES_W-1){1'b0}}}));

    a_r10_trial_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_convert |-> (trial_code == '0));

    a_r6_xfer_single: assert property (@(posedge clk) disable iff (!rst_n)
        ph_xfer |=> !ph_xfer);

    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_xfer |-> $stable(result));

    a_r9_chain: assert property (@(posedge clk) disable iff (!rst_n)
        ph_xfer |=> (ph_zref == $past(frame_start)));

    a_r3_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        ((ph_all == '0) && !frame_start) |=> (ph_all == '0));

endmodule

bind sar_slice_seq sar_slice_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .trial_code  (trial_code),
    .ph_zref     (ph_zref),
    .ph_azero    (ph_azero),
    .ph_acal     (ph_acal),
    .ph_sample   (ph_sample),
    .ph_convert  (ph_convert),
    .ph_xfer     (ph_xfer),
    .result      (result)
);

// File: tb/sar_slice_seq_test.sv
`timescale 1ns/1ps
module sar_slice_seq_test;

    localparam int RES_W = 11;
    localparam int FRAME = RES_W + 5;
    localparam int MAXV  = (1 << RES_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_start = 1'b0;
    logic [RES_W-1:0] vin = '0;
    logic             cmp_keep;
    logic [RES_W-1:0] trial_code;
    logic [RES_W-1:0] result;
    logic ph_zref, ph_azero, ph_acal, ph_sample, ph_convert, ph_xfer;
    logic [5:0]       ph;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // ideal comparator: keep the bit while the input is at or above the trial
    assign cmp_keep = (vin >= trial_code);
    assign ph = {ph_zref, ph_azero, ph_acal, ph_sample, ph_convert, ph_xfer};

    always #5 clk = ~clk;

    sar_slice_seq #(.RES_W(RES_W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .cmp_keep    (cmp_keep),
        .trial_code  (trial_code),
        .ph_zref     (ph_zref),
        .ph_azero    (ph_azero),
        .ph_acal     (ph_acal),
        .ph_sample   (ph_sample),
        .ph_convert  (ph_convert),
        .ph_xfer     (ph_xfer),
        .result      (result)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int phase_exp(input int c);
        if (c == 1) return 6'b100000;
        if (c == 2) return 6'b010000;
        if (c == 3) return 6'b001000;
        if (c == 4) return 6'b000100;
        if (c == FRAME) return 6'b000001;
        return 6'b000010;
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // entered in frame cycle 1; leaves one cycle after the transfer cycle
    task automatic do_frame(input int v, input bit chain, input bit mid, input int prev);
        vin = RES_W'(v);
        for (int c = 1; c <= FRAME; c++) begin
            check("R2 phase", int'(ph), phase_exp(c));
            check("R3 onehot", $countones(ph), 1);
            if (c >= 5 && c < FRAME) begin
                int b;
                int exp_t;
                b = RES_W - 1 - (c - 5);
                exp_t = ((v >> (b + 1)) << (b + 1)) | (1 << b);
                check("R4 trial", int'(trial_code), exp_t);
            end else begin
                check("R10 trial", int'(trial_code), 0);
            end
            if (c == FRAME) begin
                check("R5/R6 result", int'(result), v);
            end else begin
                check("R7 hold", int'(result), prev);
            end
            frame_start = (mid && (c >= 2) && (c <= 9)) || (chain && c == FRAME);
            tick();
            frame_start = 1'b0;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        tick(); tick(); tick();
        check("R1 phases", int'(ph), 0);
        check("R1 trial", int'(trial_code), 0);
        check("R1 result", int'(result), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R3 idle", int'(ph), 0);
        end

        // full sweep, frames chained through the transfer cycle (R9)
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
        for (int v = 0; v <= MAXV; v++) begin
            do_frame(v, v != MAXV, (v % 97) == 5, (v == 0) ? 0 : v - 1);
        end

        // R9: no start in transfer -> idle, R7: result held while idle
        for (int i = 0; i < 4; i++) begin
            check("R9 idle", int'(ph), 0);
            check("R7 idle hold", int'(result), MAXV);
            check("R10 idle trial", int'(trial_code), 0);
            tick();
        end

        // R8: isolated frame with start pulses inside it
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
        do_frame(1365, 1'b0, 1'b1, MAXV);
        for (int i = 0; i < 3; i++) begin
            check("R8 idle after", int'(ph), 0);
            check("R8 result", int'(result), 1365);
            tick();
        end

        // R5: alternating-bit inputs
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
        do_frame(682, 1'b1, 1'b0, 1365);
        do_frame(1, 1'b0, 1'b0, 682);
        check("R9 idle end", int'(ph), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule